// File: doc/BRIEF.md
# Three-Button Mouse Packet Encoder

This block turns one mouse event into a fixed five-byte packet and places the bytes in a small receive queue. An event is a single-cycle strobe with two signed 16-bit movement deltas and the levels of the left, middle and right buttons. The first byte is a header that carries the inverted button bits. The second byte is the horizontal movement and the third is the vertical movement, sign-flipped. Both movement bytes are clamped to a symmetric range of ±127. Two zero padding bytes close the packet.

A small state machine sends the packet, one byte per clock, into an 8-entry FIFO. The machine has six states. IDLE waits for a strobe. HEAD pushes the header, XMOV the horizontal byte, YMOV the vertical byte, and PAD0 and PAD1 the two zero bytes. The transitions are IDLE→HEAD on a strobe, HEAD→XMOV, XMOV→YMOV, YMOV→PAD0 and PAD0→PAD1, each taken unconditionally, and PAD1→IDLE. When the FIFO is full it discards arriving bytes without notice. The consumer pops bytes with a read strobe and raises its receive-available indication from the not-empty flag.

Top module: `mspkt_top`

## Requirements
- R1: Header byte = 0x87 with bit 2 cleared when the left button is pressed, bit 1 cleared for middle, bit 0 cleared for right.
- R2: Byte 2 is dx in two's complement, clamped so values above +127 give 0x7F and values below -127 give 0x81.
- R3: Byte 3 is -dy, formed at 17-bit width and then clamped to -127..+127; dy = -32768 gives 0x7F.
- R4: Bytes 4 and 5 of every packet are 0x00.
- R5: A strobe sampled in IDLE on clock edge k causes the five bytes to be pushed, in order, on edges k+1 to k+5. busy is high for exactly those five cycles. No byte is pushed while busy is low.
- R6: A strobe sampled while busy is high is ignored. The packet in flight keeps the values captured at its own strobe.
- R7: The queue returns bytes in first-in first-out order. It holds up to 8 bytes, and its pointers wrap around.
- R8: A byte pushed while the count is 8 is discarded, and the count does not change because of it.
- R9: When the queue is empty, rd_data reads 0x00. A pop on an empty queue leaves the count at 0.
- R10: After reset, count = 0, not_empty = 0 and busy = 0. q_not_empty is high exactly when q_count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_stb | input | 1 | Event strobe |
| ev_dx | input | 16 | Signed horizontal movement |
| ev_dy | input | 16 | Signed vertical movement |
| btn_l | input | 1 | Left button pressed |
| btn_m | input | 1 | Middle button pressed |
| btn_r | input | 1 | Right button pressed |
| busy | output | 1 | Packet being emitted |
| rd_en | input | 1 | Pop the head byte |
| rd_data | output | 8 | Head byte, 0x00 when empty |
| q_count | output | 4 | Bytes held in the queue |
| q_not_empty | output | 1 | Queue holds at least one byte |

## Verification
The assertions check the following on every cycle: the count never goes above 8, the count moves by at most one, a full queue stays full when nothing pops, an empty queue reads zero, busy never lasts longer than five cycles, and the count does not move while idle with no pop. The byte values (header inversion, clamping at the ±127 edges, the 17-bit negation of the most negative dy), the byte order, the strobe being ignored while busy, and which bytes are lost on overflow are shown only by the bench's sweeps. Those sweeps compare every popped byte against an arithmetic model.

// File: rtl/mspkt_pkg.sv
package mspkt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_XMOV,
        ST_YMOV,
        ST_PAD0,
        ST_PAD1
    } pkt_state_t;

    localparam int BYTE_W   = 8;
    localparam int BTN_N    = 3;
    localparam int PKT_LEN  = 5;
    localparam logic [BYTE_W-1:0] HDR_BASE = 8'h87;

endpackage

// File: rtl/mspkt_sat.sv
module mspkt_sat #(
    parameter int DELTA_W = 16,
    parameter int SAT_MAX = 127,
    parameter bit NEGATE  = 1'b0
) (
    input  logic [DELTA_W-1:0]          delta,
    output logic [mspkt_pkg::BYTE_W-1:0] byte_o
);
    localparam int EW = DELTA_W + 1;
    localparam logic signed [EW-1:0] HI = EW'(SAT_MAX);
    localparam logic signed [EW-1:0] LO = -HI;

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] val;
    logic signed [EW-1:0] clamped;

    always_comb begin
        ext = {delta[DELTA_W-1], delta};
        val = NEGATE ? -ext : ext;
        if (val > HI) begin
            clamped = HI;
        end else if (val < LO) begin
            clamped = LO;
        end else begin
            clamped = val;
        end
        byte_o = clamped[mspkt_pkg::BYTE_W-1:0];
    end
endmodule

// File: rtl/mspkt_seq.sv
module mspkt_seq
    import mspkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_stb,
    input  logic [BYTE_W-1:0] hdr_in,
    input  logic [BYTE_W-1:0] xb_in,
    input  logic [BYTE_W-1:0] yb_in,
    output logic              busy,
    output logic              push,
    output logic [BYTE_W-1:0] push_data
);
    pkt_state_t state, state_nx;
    logic [BYTE_W-1:0] hdr_q, xb_q, yb_q;
    logic capture;

    assign capture = (state == ST_IDLE) && ev_stb;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (ev_stb) state_nx = ST_HEAD;
            ST_HEAD: state_nx = ST_XMOV;
            ST_XMOV: state_nx = ST_YMOV;
            ST_YMOV: state_nx = ST_PAD0;
            ST_PAD0: state_nx = ST_PAD1;
            ST_PAD1: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
            xb_q  <= '0;
            yb_q  <= '0;
        end else if (capture) begin
            hdr_q <= hdr_in;
            xb_q  <= xb_in;
            yb_q  <= yb_in;
        end
    end

    always_comb begin
        push      = 1'b0;
        push_data = '0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_HEAD: begin push = 1'b1; push_data = hdr_q; end
            ST_XMOV: begin push = 1'b1; push_data = xb_q;  end
            ST_YMOV: begin push = 1'b1; push_data = yb_q;  end
            ST_PAD0: begin push = 1'b1; push_data = '0;    end
            ST_PAD1: begin push = 1'b1; push_data = '0;    end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/mspkt_fifo.sv
module mspkt_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          not_empty
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          accept, take;

    assign accept    = push && (count < FULL_CNT);
    assign take      = pop && (count != '0);
    assign not_empty = (count != '0);
    assign rd_data   = not_empty ? mem[rptr] : '0;

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (accept) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (take) begin
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            unique case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mspkt_top.sv
module mspkt_top
    import mspkt_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int DELTA_W  = 16,
    parameter int SAT_MAX  = 127,
    localparam int CNT_W   = $clog2(DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_stb,
    input  logic [DELTA_W-1:0] ev_dx,
    input  logic [DELTA_W-1:0] ev_dy,
    input  logic               btn_l,
    input  logic               btn_m,
    input  logic               btn_r,
    output logic               busy,
    input  logic               rd_en,
    output logic [BYTE_W-1:0]  rd_data,
    output logic [CNT_W-1:0]   q_count,
    output logic               q_not_empty
);
    logic [BTN_N-1:0]  btns;
    logic [BYTE_W-1:0] hdr_b, x_b, y_b, push_data;
    logic              push;

    assign btns  = {btn_l, btn_m, btn_r};
    assign hdr_b = HDR_BASE & ~{{(BYTE_W-BTN_N){1'b0}}, btns};

    mspkt_sat #(.DELTA_W(DELTA_W), .SAT_MAX(SAT_MAX), .NEGATE(1'b0)) u_sat_x (
        .delta  (ev_dx),
        .byte_o (x_b)
    );

    mspkt_sat #(.DELTA_W(DELTA_W), .SAT_MAX(SAT_MAX), .NEGATE(1'b1)) u_sat_y (
        .delta  (ev_dy),
        .byte_o (y_b)
    );

    mspkt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_stb    (ev_stb),
        .hdr_in    (hdr_b),
        .xb_in     (x_b),
        .yb_in     (y_b),
        .busy      (busy),
        .push      (push),
        .push_data (push_data)
    );

    mspkt_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (rd_en),
        .rd_data   (rd_data),
        .count     (q_count),
        .not_empty (q_not_empty)
    );
endmodule

// File: rtl/mspkt_chk.sv
module mspkt_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             rd_en,
    input logic [7:0]       rd_data,
    input logic [CNT_W-1:0] q_count,
    input logic             q_not_empty
);
    logic [2:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 3'd1;
        end else begin
            busy_run <= '0;
        end
    end

    AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count) <= DEPTH); // R7
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q_count) == DEPTH && !rd_en) |=> int'(q_count) == DEPTH); // R8
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !q_not_empty |-> rd_data == 8'h00); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(q_count) <= int'($past(q_count)) + 1
                  && int'(q_count) + 1 >= int'($past(q_count)))); // R10
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < 3'd5); // R5
    AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rd_en) |=> $stable(q_count)); // R5
endmodule

bind mspkt_top mspkt_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .q_count     (q_count),
    .q_not_empty (q_not_empty)
);

// File: tb/test_mspkt_top.sv
module test_mspkt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_stb = 1'b0;
    logic [15:0] ev_dx = '0;
    logic [15:0] ev_dy = '0;
    logic        btn_l = 1'b0, btn_m = 1'b0, btn_r = 1'b0;
    logic        busy;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [3:0]  q_count;
    logic        q_not_empty;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    logic [7:0] mq[$];

    always #5 clk = ~clk;

    mspkt_top i_mspkt_top (
        .clk(clk), .rst_n(rst_n), .ev_stb(ev_stb), .ev_dx(ev_dx), .ev_dy(ev_dy),
        .btn_l(btn_l), .btn_m(btn_m), .btn_r(btn_r), .busy(busy), .rd_en(rd_en),
        .rd_data(rd_data), .q_count(q_count), .q_not_empty(q_not_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sat8(input int v);
        if (v > 127) return 8'h7F;
        if (v < -127) return 8'h81;
        return v[7:0];
    endfunction

    function automatic logic [7:0] hdr8(input bit l, input bit m, input bit r);
        logic [7:0] h = 8'h87;
        if (l) h = h - 8'h04;
        if (m) h = h - 8'h02;
        if (r) h = h - 8'h01;
        return h;
    endfunction

    function automatic void mpush(input logic [7:0] b);
        if (mq.size() < 8) mq.push_back(b);
    endfunction

    function automatic void model_pkt(input int dx, input int dy, input bit l, input bit m, input bit r);
        mpush(hdr8(l, m, r));
        mpush(sat8(dx));
        mpush(sat8(-dy));
        mpush(8'h00);
        mpush(8'h00);
    endfunction

    // strobe at a negedge; bytes land on the five edges after the capture edge
    task automatic send(input int dx, input int dy, input bit l, input bit m, input bit r);
        ev_dx = 16'(dx); ev_dy = 16'(dy);
        btn_l = l; btn_m = m; btn_r = r;
        ev_stb = 1'b1;
        model_pkt(dx, dy, l, m, r);
        @(negedge clk);
        ev_stb = 1'b0;
        chk(busy == 1'b1, "R5 busy after strobe", busy, 1);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R5 busy drops after five", busy, 0);
    endtask

    task automatic drain(input string req);
        chk(int'(q_count) == mq.size(), "R10 count before drain", q_count, mq.size());
        while (mq.size() > 0) begin
            chk(q_not_empty == 1'b1, "R10 not_empty", q_not_empty, 1);
            chk(rd_data == mq[0], req, rd_data, mq[0]);
            void'(mq.pop_front());
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        chk(q_count == 4'd0, "R10 count after drain", q_count, 0);
        chk(rd_data == 8'h00, "R9 empty reads zero", rd_data, 0);
    endtask

    initial begin
        int vals[9] = '{-32768, -128, -127, -1, 0, 1, 127, 128, 32767};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(q_count == 4'd0, "R10 reset count", q_count, 0);
        chk(q_not_empty == 1'b0, "R10 reset not_empty", q_not_empty, 0);
        chk(busy == 1'b0, "R10 reset busy", busy, 0);
        chk(rd_data == 8'h00, "R9 reset read", rd_data, 0);

        // R9 pop on empty
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(q_count == 4'd0, "R9 pop empty count", q_count, 0);

        // R1 all button combinations
        for (int b = 0; b < 8; b++) begin
            send(0, 0, b[2], b[1], b[0]);
            drain("R1 header/R4 pad bytes");
        end

        // R2 R3 R4 sweep of boundary deltas
        for (int i = 0; i < 9; i++) begin
            for (int j = 0; j < 9; j++) begin
                send(vals[i], vals[j], i[0], j[0], i[1]);
                drain("R2 R3 R4 R7 packet bytes");
            end
        end

        // R6 strobe held during busy with changed data
        ev_dx = 16'(5); ev_dy = 16'(-9); btn_l = 1'b1; btn_m = 1'b0; btn_r = 1'b0;
        ev_stb = 1'b1;
        model_pkt(5, -9, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        ev_dx = 16'(100); ev_dy = 16'(100); btn_r = 1'b1;
        @(negedge clk);
        ev_stb = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R6 no second packet", busy, 0);
        chk(q_count == 4'd5, "R6 count only one packet", q_count, 5);
        drain("R6 first packet kept");

        // R8 overflow: two packets, last two bytes of second dropped
        send(3, 4, 1'b0, 1'b1, 1'b0);
        send(-200, 200, 1'b1, 1'b1, 1'b1);
        chk(q_count == 4'd8, "R8 count stays full", q_count, 8);
        @(negedge clk);
        chk(q_count == 4'd8, "R8 count unchanged", q_count, 8);
        drain("R8 R7 surviving bytes");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule